// File: doc/BRIEF.md
# I2C Target with Own-Address Match

This block is the target side of a two-wire serial bus. It oversamples the clock and data lines on the system clock, spots START and STOP conditions and keeps a bus-busy flag. After each START it shifts in a 7-bit address and compares it with an address the host has programmed. On a match it captures the direction bit, acknowledges, and then holds the clock line low until the host services the data path.

A single interrupt flag covers three events: an address match, the end of a data byte, and a bus time-out. Two status flags tell the three apart. After an address match the match flag is set. After a data byte it is clear and the time-out flag is also clear. After a time-out the time-out flag is set.

The host sees plain strobes and levels. It writes transmit bytes, reads received bytes, clears the interrupt, and either enables the interrupt output or polls the flag. The bus side is open-drain: the two drive outputs pull the lines low, and the lines are read back through the inputs.

Top module: `i2c_addr_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) sets `busBusy` and restarts address reception. A STOP (SDA rising while SCL is high) clears `busBusy` and `addrHit` and returns the block to idle.
- R2: The first 7 bits after START, taken MSB first, are compared with `ownAddr`. On a match the block pulls SDA low for the 9th clock. On a mismatch it never drives SDA and ignores the bus until the next START or STOP.
- R3: The 8th bit after START is stored in `rwBit`. 1 means the target transmits and 0 means the target receives.
- R4: After the acknowledge of a matched address, `addrHit` and `intFlag` are set and `sclHoldLow` is asserted once SCL falls after the 9th clock.
- R5: In receive mode the SCL hold ends on a `hostRd` pulse. In transmit mode it ends only on `hostWr`, and a `hostRd` pulse in transmit mode has no effect on the hold.
- R6: A received data byte is acknowledged and appears on `rxData`. It then sets `intFlag`, clears `addrHit` and holds SCL again.
- R7: Transmit data goes out MSB first. `sdaDriveLow` changes only while SCL is low. A master ACK after a transmitted byte sets `intFlag` and holds SCL.
- R8: A master NACK after a transmitted byte sets `intFlag` and releases SDA without holding SCL. Further clocks get no drive until START or STOP.
- R9: If the bus is busy or SCL is held, and neither line has an edge for `toLimit` cycles, the block sets `timeOut` and `intFlag`, clears `busBusy`, and releases both lines.
- R10: `irq` equals `intFlag` gated by `irqEn`. `irqClr` clears `intFlag` and `timeOut` unless a new event arrives in the same cycle.
- R11: With `enable` low, the block stays idle, drives neither line and reports no busy, match or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous-free synchronous reset |
| enable | input | 1 | Block enable |
| ownAddr | input | ADDR_W | Programmed own address |
| toLimit | input | TO_W | Idle-cycle limit for the time-out |
| sclIn | input | 1 | SCL line as seen on the bus |
| sdaIn | input | 1 | SDA line as seen on the bus |
| sclHoldLow | output | 1 | Pull SCL low (clock stretch) |
| sdaDriveLow | output | 1 | Pull SDA low (ACK or a transmitted 0) |
| hostWr | input | 1 | Host write strobe for transmit data |
| hostWrData | input | DATA_W | Transmit byte |
| hostRd | input | 1 | Host read strobe (real or dummy read) |
| rxData | output | DATA_W | Last received byte |
| irqEn | input | 1 | Interrupt output enable |
| irqClr | input | 1 | Clear interrupt and time-out flags |
| irq | output | 1 | Interrupt request |
| intFlag | output | 1 | Pollable interrupt flag |
| busBusy | output | 1 | Bus between START and STOP |
| addrHit | output | 1 | Address-match status |
| rwBit | output | 1 | Captured direction bit |
| timeOut | output | 1 | Time-out status |

## Verification
A wrong state in the bit sequencer shows at the bus within one SCL period. Such an error misplaces the acknowledge or stretches the clock at the wrong point, so the master model sees a missing ACK or a wrong byte on the very next transfer. A wrong status register appears at the host ports when the interrupt is raised: `addrHit`, `timeOut` or `rwBit` disagrees with the event that caused it. A stuck time-out counter shows as a hold that is never released, or as a release that comes too early, within a few tens of cycles of the programmed limit. The reference model also checks on every clock that the SDA drive never moves while SCL is high.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADA1, ST_ADA2, ST_HOLD, ST_TXGO, ST_TX,
    ST_TXA1, ST_TXA2, ST_RX, ST_RXA1, ST_RXA2, ST_SKIP
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic capRx;
    logic clrCnt;
  } dpStrobe_t;

  // synchronised line levels and decoded bus events
  typedef struct packed {
    logic sclS;
    logic sdaS;
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } busEvt_t;

endpackage

// File: rtl/i2c_slv_dpath.sv
module i2c_slv_dpath
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TO_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] txData,
  input  logic              toRun,
  input  logic [TO_W-1:0]   toLimit,
  output busEvt_t           evt,
  output logic [ADDR_W-1:0] addrBits,
  output logic              txBit,
  output logic              lastBit,
  output logic [DATA_W-1:0] rxData,
  output logic              toHit
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev, sclS, sdaS, anyEdge;
  logic [DATA_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic [TO_W-1:0]   toCnt;

  // line synchronisers, idle-high after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign anyEdge = (sclS ^ sclPrev) | (sdaS ^ sdaPrev);

  always_comb begin
    evt.sclS     = sclS;
    evt.sdaS     = sdaS;
    evt.sclRise  = sclS & ~sclPrev;
    evt.sclFall  = ~sclS & sclPrev;
    evt.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
    evt.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  end

  // shared shifter for address, receive and transmit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.loadTx) begin
      shiftReg <= txData;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaS};
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (strb.clrCnt || strb.loadTx) begin
      bitCnt <= '0;
    end else if (strb.shiftIn || strb.shiftOut) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (strb.capRx) begin
      rxData <= {shiftReg[DATA_W-2:0], sdaS};
    end
  end

  assign addrBits = shiftReg[ADDR_W-1:0];
  assign txBit    = shiftReg[DATA_W-1];
  assign lastBit  = (bitCnt == CNT_W'(DATA_W - 1));

  // idle-line time-out counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (!toRun || anyEdge || toHit) begin
      toCnt <= '0;
    end else if (toCnt != toLimit) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  assign toHit = toRun && (toCnt == toLimit);

endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  busEvt_t           evt,
  input  logic              lastBit,
  input  logic [ADDR_W-1:0] addrBits,
  input  logic              txBit,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              irqClr,
  input  logic              toHit,
  output dpStrobe_t         strb,
  output logic              toRun,
  output logic              sclHold,
  output logic              sdaLow,
  output logic              busy,
  output logic              addrHit,
  output logic              rwBit,
  output logic              toFlag,
  output logic              intFlag
);
  ctlState_t state;
  logic txMode, txDrive, ackLow, mstAck;
  logic quiet, setEv, addrOk;

  assign quiet  = !toHit && !evt.startDet && !evt.stopDet;
  assign addrOk = (addrBits == ownAddr);

  always_comb begin
    strb          = '0;
    strb.shiftIn  = enable && evt.sclRise && (state == ST_ADDR || state == ST_RX);
    strb.capRx    = enable && evt.sclRise && lastBit && state == ST_RX;
    strb.shiftOut = enable && evt.sclFall && state == ST_TX;
    strb.loadTx   = enable && quiet && state == ST_HOLD && txMode && hostWr;
    strb.clrCnt   = enable && (evt.startDet ||
                               (state == ST_HOLD && !txMode && hostRd));
  end

  always_comb begin
    setEv = 1'b0;
    if (enable) begin
      if (toHit) begin
        setEv = 1'b1;
      end else if (quiet && evt.sclFall &&
                   (state == ST_ADA2 || state == ST_RXA2 || state == ST_TXA2)) begin
        setEv = 1'b1;
      end
    end
  end

  assign sdaLow = ackLow | (txDrive & ~txBit);
  assign toRun  = busy | sclHold;

  always_ff @(posedge clk) begin
    if (!rstN || !enable) begin
      state   <= ST_IDLE;
      txMode  <= 1'b0;
      txDrive <= 1'b0;
      ackLow  <= 1'b0;
      mstAck  <= 1'b0;
      sclHold <= 1'b0;
      busy    <= 1'b0;
      addrHit <= 1'b0;
      rwBit   <= 1'b0;
      toFlag  <= 1'b0;
      intFlag <= 1'b0;
    end else begin
      if (setEv) begin
        intFlag <= 1'b1;
      end else if (irqClr) begin
        intFlag <= 1'b0;
      end

      if (toHit) begin
        state   <= ST_IDLE;
        toFlag  <= 1'b1;
        busy    <= 1'b0;
        addrHit <= 1'b0;
        sclHold <= 1'b0;
        ackLow  <= 1'b0;
        txDrive <= 1'b0;
      end else begin
        if (irqClr) toFlag <= 1'b0;
        if (evt.stopDet) begin
          state   <= ST_IDLE;
          busy    <= 1'b0;
          addrHit <= 1'b0;
          sclHold <= 1'b0;
          ackLow  <= 1'b0;
          txDrive <= 1'b0;
        end else if (evt.startDet) begin
          state   <= ST_ADDR;
          busy    <= 1'b1;
          addrHit <= 1'b0;
          sclHold <= 1'b0;
          ackLow  <= 1'b0;
          txDrive <= 1'b0;
        end else begin
          case (state)
            ST_ADDR: if (evt.sclRise && lastBit) begin
              if (addrOk) begin
                rwBit  <= evt.sdaS;
                txMode <= evt.sdaS;
                state  <= ST_ADA1;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_ADA1: if (evt.sclFall) begin
              ackLow <= 1'b1;
              state  <= ST_ADA2;
            end
            ST_ADA2: if (evt.sclFall) begin
              ackLow  <= 1'b0;
              sclHold <= 1'b1;
              addrHit <= 1'b1;
              state   <= ST_HOLD;
            end
            ST_HOLD: begin
              if (txMode && hostWr) begin
                txDrive <= 1'b1;
                state   <= ST_TXGO;
              end else if (!txMode && hostRd) begin
                sclHold <= 1'b0;
                state   <= ST_RX;
              end
            end
            ST_TXGO: begin
              sclHold <= 1'b0;
              state   <= ST_TX;
            end
            ST_TX: if (evt.sclFall && lastBit) begin
              txDrive <= 1'b0;
              state   <= ST_TXA1;
            end
            ST_TXA1: if (evt.sclRise) begin
              mstAck <= ~evt.sdaS;
              state  <= ST_TXA2;
            end
            ST_TXA2: if (evt.sclFall) begin
              addrHit <= 1'b0;
              if (mstAck) begin
                sclHold <= 1'b1;
                state   <= ST_HOLD;
              end else begin
                state <= ST_SKIP;
              end
            end
            ST_RX: if (evt.sclRise && lastBit) begin
              state <= ST_RXA1;
            end
            ST_RXA1: if (evt.sclFall) begin
              ackLow <= 1'b1;
              state  <= ST_RXA2;
            end
            ST_RXA2: if (evt.sclFall) begin
              ackLow  <= 1'b0;
              sclHold <= 1'b1;
              addrHit <= 1'b0;
              state   <= ST_HOLD;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R7
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && !$past(toHit) && !$stable(sdaLow)) |-> !evt.sclS);

  // R4
  match_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrHit) |-> sclHold);

  // R9
  to_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && toHit) |=> (!busy && !sclHold && !sdaLow && toFlag));

  // R10
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && irqClr && !setEv) |=> !intFlag);

  // R1
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && evt.stopDet) |=> !busy);

  // R5
  tx_hold_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && quiet && state == ST_HOLD && txMode && hostRd && !hostWr) |=> sclHold);

endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_slv_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TO_W        = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic [TO_W-1:0]   toLimit,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclHoldLow,
  output logic              sdaDriveLow,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRd,
  output logic [DATA_W-1:0] rxData,
  input  logic              irqEn,
  input  logic              irqClr,
  output logic              irq,
  output logic              intFlag,
  output logic              busBusy,
  output logic              addrHit,
  output logic              rwBit,
  output logic              timeOut
);
  busEvt_t           evt;
  dpStrobe_t         strb;
  logic [ADDR_W-1:0] addrBits;
  logic              txBit, lastBit, toRun, toHit;

  i2c_slv_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .TO_W(TO_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb),
    .txData(hostWrData), .toRun(toRun), .toLimit(toLimit), .evt(evt),
    .addrBits(addrBits), .txBit(txBit), .lastBit(lastBit), .rxData(rxData),
    .toHit(toHit)
  );

  i2c_slv_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .evt(evt), .lastBit(lastBit),
    .addrBits(addrBits), .txBit(txBit), .ownAddr(ownAddr), .hostWr(hostWr),
    .hostRd(hostRd), .irqClr(irqClr), .toHit(toHit), .strb(strb),
    .toRun(toRun), .sclHold(sclHoldLow), .sdaLow(sdaDriveLow), .busy(busBusy),
    .addrHit(addrHit), .rwBit(rwBit), .toFlag(timeOut), .intFlag(intFlag)
  );

  assign irq = intFlag & irqEn;

endmodule

// File: tb/i2c_addr_slave_test.sv
module i2c_addr_slave_test;
  localparam int HP = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN = 1'b0, enable = 1'b0;
  logic [6:0]  ownAddr = OWN;
  logic [15:0] toLimit = 16'd500;
  logic mScl0 = 1'b0, mSda0 = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0, irqEn = 1'b1, irqClr = 1'b0;
  logic [7:0] hostWrData = 8'h00;
  logic sclLine, sdaLine, sclHoldLow, sdaDriveLow, irq, intFlag;
  logic busBusy, addrHit, rwBit, timeOut;
  logic [7:0] rxData;

  assign sclLine = !(mScl0 || sclHoldLow);
  assign sdaLine = !(mSda0 || sdaDriveLow);

  i2c_addr_slave uut (
    .clk(clk), .rstN(rstN), .enable(enable), .ownAddr(ownAddr), .toLimit(toLimit),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclHoldLow(sclHoldLow), .sdaDriveLow(sdaDriveLow),
    .hostWr(hostWr), .hostWrData(hostWrData), .hostRd(hostRd), .rxData(rxData),
    .irqEn(irqEn), .irqClr(irqClr), .irq(irq), .intFlag(intFlag), .busBusy(busBusy),
    .addrHit(addrHit), .rwBit(rwBit), .timeOut(timeOut)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one SCL period driven by the master model; honours clock stretching
  task automatic mClock(input bit b, output bit s);
    mSda0 = !b;
    tick(HP);
    mScl0 = 1'b0;
    while (!sclLine) tick(1);
    tick(HP / 2);
    s = sdaLine;
    tick(HP / 2);
    mScl0 = 1'b1;
    tick(HP);
  endtask

  task automatic mStart();
    mSda0 = 1'b1;
    tick(HP);
    mScl0 = 1'b1;
    tick(HP);
  endtask

  task automatic mStop();
    mSda0 = 1'b1;
    tick(HP);
    mScl0 = 1'b0;
    while (!sclLine) tick(1);
    tick(HP);
    mSda0 = 1'b0;
    tick(HP);
  endtask

  task automatic mSendByte(input logic [7:0] d, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) mClock(d[i], s);
    mClock(1'b1, s);
    ack = !s;
  endtask

  task automatic mRecvByte(output logic [7:0] d, input bit giveAck);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      mClock(1'b1, s);
      d[i] = s;
    end
    mClock(!giveAck, s);
  endtask

  task automatic hostRdP();
    hostRd = 1'b1; tick(1); hostRd = 1'b0; tick(2);
  endtask

  task automatic hostWrP(input logic [7:0] d);
    hostWrData = d; hostWr = 1'b1; tick(1); hostWr = 1'b0; tick(2);
  endtask

  task automatic clrIrq();
    irqClr = 1'b1; tick(1); irqClr = 1'b0; tick(1);
  endtask

  // bus-rule reference model, every clock: SDA drive may only move while SCL is low (R7)
  logic prevDrv = 1'b0, prevScl = 1'b1;
  always @(posedge clk) begin
    #2;
    if (rstN && enable && !done) begin
      tests++;
      if (sdaDriveLow != prevDrv && sclLine && prevScl) begin
        fails++;
        $display("FAIL R7 SDA drive moved with SCL high: actual=%0d expected=%0d",
                 sdaDriveLow, prevDrv);
      end
    end
    prevDrv = sdaDriveLow;
    prevScl = sclLine;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] d;
    tick(3);
    rstN = 1'b1;
    tick(2);
    chkEq("R11 reset busy", busBusy, 0);
    chkEq("R11 reset hold", sclHoldLow, 0);
    chkEq("R11 reset sda", sdaDriveLow, 0);
    chkEq("R10 reset irq", irq, 0);
    enable = 1'b1;
    tick(4);

    // receive transfer
    mStart();
    chkEq("R1 busy after START", busBusy, 1);
    mSendByte({OWN, 1'b0}, ack);
    chkEq("R2 ack on match", ack, 1);
    chkEq("R3 rwBit write", rwBit, 0);
    chkEq("R4 addrHit", addrHit, 1);
    chkEq("R4 irq on match", irq, 1);
    chkEq("R4 SCL held", sclHoldLow, 1);
    tick(40);
    chkEq("R5 hold persists", sclHoldLow, 1);
    clrIrq();
    chkEq("R10 irqClr clears flag", intFlag, 0);
    hostRdP();
    chkEq("R5 dummy read releases SCL", sclHoldLow, 0);
    mSendByte(8'hA5, ack);
    chkEq("R6 data ack", ack, 1);
    chkEq("R6 rxData", rxData, 8'hA5);
    chkEq("R6 irq on byte", intFlag, 1);
    chkEq("R6 addrHit cleared", addrHit, 0);
    chkEq("R6 timeOut clear", timeOut, 0);
    chkEq("R6 SCL held", sclHoldLow, 1);
    clrIrq();
    hostRdP();
    mSendByte(8'h3C, ack);
    chkEq("R6 second byte", rxData, 8'h3C);
    clrIrq();
    hostRdP();
    mStop();
    chkEq("R1 busy cleared on STOP", busBusy, 0);

    // mismatched address
    mStart();
    mSendByte({7'h11, 1'b0}, ack);
    chkEq("R2 no ack on mismatch", ack, 0);
    chkEq("R2 no irq on mismatch", intFlag, 0);
    chkEq("R2 no hold on mismatch", sclHoldLow, 0);
    mSendByte(8'h00, ack);
    chkEq("R2 later byte ignored", ack, 0);
    mStop();

    // transmit transfer
    mStart();
    mSendByte({OWN, 1'b1}, ack);
    chkEq("R2 ack on read address", ack, 1);
    chkEq("R3 rwBit read", rwBit, 1);
    chkEq("R4 SCL held for transmit", sclHoldLow, 1);
    clrIrq();
    hostRdP();
    tick(20);
    chkEq("R5 read ignored in transmit", sclHoldLow, 1);
    hostWrP(8'h3C);
    mRecvByte(d, 1'b1);
    chkEq("R7 first tx byte", d, 8'h3C);
    chkEq("R7 irq after acked byte", intFlag, 1);
    chkEq("R7 hold after acked byte", sclHoldLow, 1);
    chkEq("R7 addrHit cleared", addrHit, 0);
    clrIrq();
    irqEn = 1'b0;
    hostWrP(8'h81);
    mRecvByte(d, 1'b0);
    chkEq("R7 second tx byte", d, 8'h81);
    chkEq("R8 no hold after NACK", sclHoldLow, 0);
    chkEq("R8 SDA released", sdaDriveLow, 0);
    chkEq("R10 irq masked", irq, 0);
    chkEq("R10 flag still set", intFlag, 1);
    mRecvByte(d, 1'b0);
    chkEq("R8 no drive after NACK", d, 8'hFF);
    irqEn = 1'b1;
    clrIrq();
    mStop();

    // time-out with bus busy
    toLimit = 16'd40;
    mStart();
    tick(60);
    chkEq("R9 timeOut set", timeOut, 1);
    chkEq("R9 busy cleared", busBusy, 0);
    chkEq("R9 irq", irq, 1);
    clrIrq();
    chkEq("R10 clear timeOut", timeOut, 0);
    mStop();

    // time-out while stretching
    mStart();
    mSendByte({OWN, 1'b0}, ack);
    chkEq("R4 match before time-out", sclHoldLow, 1);
    tick(60);
    chkEq("R9 hold released", sclHoldLow, 0);
    chkEq("R9 timeOut in hold", timeOut, 1);
    clrIrq();
    mStop();
    toLimit = 16'd500;

    // disabled
    enable = 1'b0;
    tick(2);
    mStart();
    mSendByte({OWN, 1'b0}, ack);
    chkEq("R11 no ack when disabled", ack, 0);
    chkEq("R11 no busy when disabled", busBusy, 0);
    chkEq("R11 no hold when disabled", sclHoldLow, 0);
    chkEq("R11 no irq when disabled", intFlag, 0);
    mStop();
    enable = 1'b1;
    tick(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule